// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block links two parallel buses, called side A and side B. Each side has its own storage register, and each register is loaded from its own bus by its own clock. Data can go from A to B or from B to A. In each direction a select input picks one of two sources: the value on the source bus now, or the value held in that bus's register. The driven value is always the bitwise inverse of the chosen source.

A direction input and an active-low enable decide which side, if any, is driven. Each side's output is modelled as a data vector plus an enable flag. A pad-level wrapper can map a side whose flag is low to high impedance. The registers clock whether or not any output is enabled. Data can therefore be stored quietly and driven later, or stored on one side while stored data is driven in the other direction.

Top module: `regbus_xcvr`

## Requirements
- R1: A reset held high across a rising edge of each load clock clears both storage registers to zero. This is observed as all-ones on the enabled output when the stored source is selected.
- R2: The A register captures `a_in` on each rising edge of `clk_a` and keeps its value between edges.
- R3: The B register captures `b_in` on each rising edge of `clk_b` and keeps its value between edges.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 and both `a_out` and `b_out` are all zeros.
- R5: While `oe_n` is 0 and `dir` is 1 (toward B), `b_oe` is 1 and `a_oe` is 0, and `a_out` is all zeros.
- R6: While `oe_n` is 0 and `dir` is 0 (toward A), `a_oe` is 1 and `b_oe` is 0, and `b_out` is all zeros.
- R7: When B is driven and `sel_ab` is 0, `b_out` equals the bitwise inverse of the present `a_in`, with no clock edge needed.
- R8: When B is driven and `sel_ab` is 1, `b_out` equals the bitwise inverse of the A register.
- R9: When A is driven, `a_out` equals the inverse of the present `b_in` if `sel_ba` is 0, and the inverse of the B register if `sel_ba` is 1.
- R10: Both registers load on their clock edges while `oe_n` is 1.
- R11: Clocking the A register while stored B data is driven onto A leaves `a_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Load clock of the A-side register |
| clk_b | input | 1 | Load clock of the B-side register |
| rst | input | 1 | Synchronous active-high reset, sampled by each load clock |
| a_in | input | 8 | Value present on bus A |
| b_in | input | 8 | Value present on bus B |
| sel_ab | input | 1 | A-to-B source select: 0 = live A, 1 = stored A |
| sel_ba | input | 1 | B-to-A source select: 0 = live B, 1 = stored B |
| dir | input | 1 | Transfer direction: 1 = drive B, 0 = drive A |
| oe_n | input | 1 | Active-low enable of both outputs |
| a_out | output | 8 | Inverted data driven onto A, zero when A is not enabled |
| a_oe | output | 1 | A-side drive enable |
| b_out | output | 8 | Inverted data driven onto B, zero when B is not enabled |
| b_oe | output | 1 | B-side drive enable |

## Verification
The select, enable and inversion logic has no register in its path. The outputs therefore change in the same cycle as an input change, and they follow a register's new contents as soon as its load clock rises. The driver applies inputs at a falling edge of the bench clock. It then pulses any load clock a short time later and queues the expected outputs. The monitor compares at the next rising edge, after every change has settled, so each result is checked zero load-clock cycles after its stimulus.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  typedef enum logic {
    XFER_TO_A = 1'b0,
    XFER_TO_B = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/xcv_store_reg.sv
module xcv_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcv_oe_ctrl.sv
module xcv_oe_ctrl
  import regbus_xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output logic en_a,
  output logic en_b
);
  xfer_dir_e dsel;

  always_comb begin
    dsel = xfer_dir_e'(dir);
    en_a = 1'b0;
    en_b = 1'b0;
    if (!oe_n) begin
      unique case (dsel)
        XFER_TO_A: en_a = 1'b1;
        XFER_TO_B: en_b = 1'b1;
        default:   en_a = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/xcv_path_sel.sv
module xcv_path_sel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         use_stored,
  input  logic         en,
  output logic [W-1:0] drive
);
  logic [W-1:0] src;

  always_comb begin
    src   = use_stored ? stored : live;
    drive = en ? ~src : '0;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned W = DEF_WIDTH
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         dir,
  input  logic         oe_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] stored_a;
  logic [W-1:0] stored_b;
  logic         en_a;
  logic         en_b;

  xcv_store_reg #(.W(W)) u_reg_a (.clk(clk_a), .rst(rst), .d(a_in), .q(stored_a));
  xcv_store_reg #(.W(W)) u_reg_b (.clk(clk_b), .rst(rst), .d(b_in), .q(stored_b));

  xcv_oe_ctrl u_oe (.oe_n(oe_n), .dir(dir), .en_a(en_a), .en_b(en_b));

  xcv_path_sel #(.W(W)) u_to_b (
    .live(a_in), .stored(stored_a), .use_stored(sel_ab), .en(en_b), .drive(b_out)
  );
  xcv_path_sel #(.W(W)) u_to_a (
    .live(b_in), .stored(stored_b), .use_stored(sel_ba), .en(en_a), .drive(a_out)
  );

  assign a_oe = en_a;
  assign b_oe = en_b;
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         dir,
  input logic         oe_n,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] stored_a,
  input logic [W-1:0] stored_b
);
  assert_reset_a_R1: assert property (@(posedge clk_a) rst |=> stored_a == '0);
  assert_reset_b_R1: assert property (@(posedge clk_b) rst |=> stored_b == '0);

  assert_load_a_R2: assert property (@(posedge clk_a) disable iff (rst)
    !$past(rst) |-> stored_a == $past(a_in));
  assert_load_b_R3: assert property (@(posedge clk_b) disable iff (rst)
    !$past(rst) |-> stored_b == $past(b_in));

  assert_quiet_R4: assert property (@(posedge clk_a) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));
  assert_dir_b_R5: assert property (@(posedge clk_a) disable iff (rst)
    (!oe_n && dir) |-> (b_oe && !a_oe));
  assert_dir_a_R6: assert property (@(posedge clk_a) disable iff (rst)
    (!oe_n && !dir) |-> (a_oe && !b_oe));

  assert_live_ab_R7: assert property (@(posedge clk_a) disable iff (rst)
    (b_oe && !sel_ab) |-> b_out == ~a_in);
  assert_stored_ab_R8: assert property (@(posedge clk_a) disable iff (rst)
    (b_oe && sel_ab) |-> b_out == ~stored_a);
  assert_path_ba_R9: assert property (@(posedge clk_b) disable iff (rst)
    a_oe |-> a_out == (sel_ba ? ~stored_b : ~b_in));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .a_in(a_in), .b_in(b_in),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .dir(dir), .oe_n(oe_n),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .stored_a(stored_a), .stored_b(stored_b)
);

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;
  localparam int unsigned W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 20000;

  typedef struct {
    string        tag;
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;
  } exp_t;

  logic clk = 1'b0;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic sel_ab = 1'b0;
  logic sel_ba = 1'b0;
  logic dir = 1'b0;
  logic oe_n = 1'b1;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  logic [W-1:0] m_a = '0;
  logic [W-1:0] m_b = '0;
  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regbus_xcvr #(.W(W)) u_regbus_xcvr (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .a_in(a_in), .b_in(b_in),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .dir(dir), .oe_n(oe_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic drive(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sab, input logic sba, input logic d, input logic oen,
                       input bit pa, input bit pb);
    exp_t e;
    @(negedge clk);
    a_in = a; b_in = b; sel_ab = sab; sel_ba = sba; dir = d; oe_n = oen;
    #1;
    if (pa || pb) begin
      clk_a = pa; clk_b = pb;
      if (pa) m_a = rst ? '0 : a;
      if (pb) m_b = rst ? '0 : b;
      #1;
      clk_a = 1'b0; clk_b = 1'b0;
    end
    e.tag  = tag;
    e.b_oe = !oen && d;
    e.a_oe = !oen && !d;
    e.b_out = e.b_oe ? ~(sab ? m_a : a) : '0;
    e.a_out = e.a_oe ? ~(sba ? m_b : b) : '0;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
        n_bad++;
        $display("FAIL %s: got a_out=%h a_oe=%b b_out=%h b_oe=%b exp a_out=%h a_oe=%b b_out=%h b_oe=%b",
                 e.tag, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles exp below %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive("R1 reset", 8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    rst = 1'b0;
    // R1: stored zeros seen as all ones
    drive("R1 stored A after reset", 8'h12, 8'h34, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    drive("R1 stored B after reset", 8'h12, 8'h34, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R10: load while both sides are off
    drive("R10 R4 load while off", 8'hA5, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    drive("R10 R8 stored A read", 8'h00, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    drive("R10 R9 stored B read", 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R2: hold between edges, then capture
    drive("R2 hold", 8'h77, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive("R2 capture", 8'h81, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    // R3: capture B only
    drive("R3 capture", 8'h00, 8'h6E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    drive("R3 hold", 8'h00, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: live changes without clock
    drive("R7 live a", 8'hF0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive("R7 live a change", 8'h0F, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R11: clock A while stored B drives A
    drive("R11 store A while stored B out", 8'h99, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    drive("R11 store A again", 8'h44, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    drive("R11 R8 A register check", 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // every dir / enable / select combination
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] av, bv;
      string t;
      av = W'(8'h13 * (i + 1));
      bv = W'(8'hE7 ^ (8'h29 * i));
      if (i[1]) t = "R4";
      else if (i[0]) t = i[2] ? "R5 R8" : "R5 R7";
      else t = "R6 R9";
      drive(t, av, bv, i[2], i[3], i[0], i[1], (i % 5) == 0, (i % 3) == 0);
    end
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule